// File: doc/BRIEF.md
# Three-Notation Signed Fraction Adder/Subtractor

This block adds or subtracts two signed binary fractions held in 11-bit words. Bit 10 is the sign (0 positive, 1 negative), the binary point sits just right of it, and bits 9:0 are the fraction. A two-bit notation select picks how the word is read: sign-and-magnitude, ones' complement or twos' complement. A one-bit operation select picks add or subtract.

A one-cycle start pulse captures both operands, the notation and the operation while the block is idle. The block raises busy and returns the result with an overflow flag under a one-cycle done pulse. In twos' and ones' complement, and in sign-and-magnitude when no recomplement is needed, done comes one clock after capture. A sign-and-magnitude sum of unlike signs that produces no carry out of the top fraction bit is complemented in a second cycle, so its done comes two clocks after capture.

Top module: `snadd_top`

## Requirements
- R1: After reset, busy, done, ovf and result are all 0.
- R2: A start sampled high while busy is 0 captures a, b, mode and sub. busy is 1 from the next cycle until done. done is high for exactly one cycle and busy is 0 in that cycle.
- R3: A start sampled while busy is 1 is ignored. The result under the pending done is the one from the captured operands, and no further done follows.
- R4: Mode 2'b10 or 2'b11 selects twos' complement. The result is a + b, or a + ~b + 1 for subtract, taken modulo 2^11 with the carry out of bit 10 dropped. done comes one clock after capture.
- R5: In twos' complement, ovf is 1 exactly when the true sum lies outside -1 .. 1023/1024. The word 0x400 stands for -1.
- R6: Mode 2'b01 selects ones' complement. A negative number is the bitwise inverse of its magnitude. Bits 10:0 are added, and a carry out of bit 10 is added back at bit 0. Subtract inverts all of b first. Either zero word may stand for a zero result. done comes one clock after capture.
- R7: In ones' complement, ovf is 1 exactly when the true sum magnitude exceeds 1023/1024.
- R8: Mode 2'b00 selects sign-and-magnitude. When a's sign equals b's effective sign, the magnitudes are added and the result takes that sign. ovf is the carry out of bit 9, and done comes one clock after capture.
- R9: In sign-and-magnitude with unlike effective signs and |a| > |b|, the result is |a| - |b| with a's sign, ovf is 0, and done comes one clock after capture.
- R10: In sign-and-magnitude with unlike effective signs and |a| <= |b|, the result is |b| - |a| with b's effective sign, ovf is 0, and done comes two clocks after capture. Equal magnitudes give a zero magnitude carrying that sign.
- R11: In sign-and-magnitude, subtract inverts only b's sign bit, and the R8 to R10 rules then apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled while idle |
| mode | input | 2 | Notation: 00 sign-magnitude, 01 ones', 1x twos' |
| sub | input | 1 | 0 add, 1 subtract |
| a | input | 11 | Augend / minuend |
| b | input | 11 | Addend / subtrahend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 11 | Sum or difference, valid with done |
| ovf | output | 1 | Overflow, valid with done |

## Verification
The assertions assume that start is a clean synchronous level and that operands only matter in a cycle where start is sampled while idle. They also assume that mode and sub are never X when captured. The bench drives every input on the falling edge and holds start for one cycle per request. Where it deliberately raises start again, it does so only in a cycle where busy is known to be high, so every accepted request carries defined operands. Results are read on the falling edge after done and compared as signed values, so both zero words count as zero except where R10 fixes the sign.

// File: rtl/snadd_pkg.sv
package snadd_pkg;

  typedef enum logic [1:0] {
    NOTE_SM  = 2'b00,
    NOTE_OC  = 2'b01,
    NOTE_TC  = 2'b10,
    NOTE_TC2 = 2'b11
  } notation_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CALC = 2'b01,
    ST_FIX  = 2'b10
  } stage_e;

endpackage

// File: rtl/snadd_core.sv
module snadd_core #(
  parameter int unsigned MAG_W = 10
) (
  input  logic [1:0]       mode,
  input  logic             sub,
  input  logic [MAG_W:0]   a,
  input  logic [MAG_W:0]   b,
  output logic [MAG_W:0]   sum,
  output logic             ovf,
  output logic             need_fix
);
  import snadd_pkg::*;

  localparam int unsigned W = MAG_W + 1;

  // twos' complement: {ovf, sum}
  function automatic logic [W:0] tc_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic s);
    logic [W-1:0] yy;
    logic [W-1:0] r;
    yy = s ? ~y : y;
    r  = x + yy + {{(W-1){1'b0}}, s};
    return {(x[W-1] == yy[W-1]) && (r[W-1] != x[W-1]), r};
  endfunction

  // ones' complement with end-around carry: {ovf, sum}
  function automatic logic [W:0] oc_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic s);
    logic [W-1:0] yy;
    logic [W:0]   raw;
    logic [W-1:0] r;
    yy  = s ? ~y : y;
    raw = {1'b0, x} + {1'b0, yy};
    r   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    return {(x[W-1] == yy[W-1]) && (r[W-1] != x[W-1]), r};
  endfunction

  // sign-and-magnitude: {need_fix, ovf, sum}; when need_fix the
  // magnitude field still has to be inverted in the next cycle
  function automatic logic [W+1:0] sm_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic s);
    logic             ys;
    logic [MAG_W:0]   t;
    logic [MAG_W-1:0] xm;
    logic [MAG_W-1:0] ym;
    xm = x[MAG_W-1:0];
    ym = y[MAG_W-1:0];
    ys = y[W-1] ^ s;
    if (x[W-1] == ys) begin
      t = {1'b0, xm} + {1'b0, ym};
      return {1'b0, t[MAG_W], x[W-1], t[MAG_W-1:0]};
    end
    t = {1'b0, xm} + {1'b0, ~ym};
    if (t[MAG_W])
      return {1'b0, 1'b0, x[W-1], t[MAG_W-1:0] + {{(MAG_W-1){1'b0}}, 1'b1}};
    return {1'b1, 1'b0, ys, t[MAG_W-1:0]};
  endfunction

  logic [W:0]   tc_r;
  logic [W:0]   oc_r;
  logic [W+1:0] sm_r;

  always_comb begin
    tc_r = tc_add(a, b, sub);
    oc_r = oc_add(a, b, sub);
    sm_r = sm_add(a, b, sub);
    unique case (notation_e'(mode))
      NOTE_SM: begin
        sum      = sm_r[W-1:0];
        ovf      = sm_r[W];
        need_fix = sm_r[W+1];
      end
      NOTE_OC: begin
        sum      = oc_r[W-1:0];
        ovf      = oc_r[W];
        need_fix = 1'b0;
      end
      default: begin
        sum      = tc_r[W-1:0];
        ovf      = tc_r[W];
        need_fix = 1'b0;
      end
    endcase
  end

  always_comb begin
    a_r8_sm_fix_no_ovf: assert (!(need_fix && ovf));
  end

endmodule

// File: rtl/snadd_recomp.sv
module snadd_recomp #(
  parameter int unsigned MAG_W = 10
) (
  input  logic [MAG_W:0] partial,
  output logic [MAG_W:0] fixed
);
  // the sign was settled in the first cycle; only the magnitude flips
  assign fixed = {partial[MAG_W], ~partial[MAG_W-1:0]};
endmodule

// File: rtl/snadd_ctrl.sv
module snadd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_fix,
  output logic cap_en,
  output logic calc_stage,
  output logic fix_stage,
  output logic busy,
  output logic done
);
  import snadd_pkg::*;

  stage_e st_q;
  stage_e st_d;

  assign busy       = (st_q != ST_IDLE);
  assign cap_en     = start && (st_q == ST_IDLE);
  assign calc_stage = (st_q == ST_CALC);
  assign fix_stage  = (st_q == ST_FIX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_CALC;
      ST_CALC: st_d = need_fix ? ST_FIX : ST_IDLE;
      ST_FIX:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= (calc_stage && !need_fix) || fix_stage;
    end
  end

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/snadd_top.sv
module snadd_top #(
  parameter int unsigned MAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             sub,
  input  logic [MAG_W:0]   a,
  input  logic [MAG_W:0]   b,
  output logic             busy,
  output logic             done,
  output logic [MAG_W:0]   result,
  output logic             ovf
);
  import snadd_pkg::*;

  localparam int unsigned W = MAG_W + 1;

  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [1:0]   mode_q;
  logic         sub_q;
  logic [W-1:0] res_q;
  logic         ovf_q;

  logic [W-1:0] core_sum;
  logic         core_ovf;
  logic         core_fix;
  logic [W-1:0] fixed_w;
  logic         cap_en;
  logic         calc_stage;
  logic         fix_stage;

  snadd_core #(.MAG_W(MAG_W)) core_i (
    .mode(mode_q), .sub(sub_q), .a(a_q), .b(b_q),
    .sum(core_sum), .ovf(core_ovf), .need_fix(core_fix)
  );

  snadd_recomp #(.MAG_W(MAG_W)) recomp_i (
    .partial(res_q), .fixed(fixed_w)
  );

  snadd_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .need_fix(core_fix),
    .cap_en(cap_en), .calc_stage(calc_stage), .fix_stage(fix_stage),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= '0;
      sub_q  <= 1'b0;
    end else if (cap_en) begin
      a_q    <= a;
      b_q    <= b;
      mode_q <= mode;
      sub_q  <= sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (calc_stage) begin
      res_q <= core_sum;
      ovf_q <= core_ovf;
    end else if (fix_stage) begin
      res_q <= fixed_w;
      ovf_q <= 1'b0;
    end
  end

  assign result = res_q;
  assign ovf    = ovf_q;

  a_r3_ops_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(mode_q) && $stable(sub_q)));
  a_r10_fix_only_sm: assert property (@(posedge clk) disable iff (!rst_n)
    fix_stage |-> (mode_q == NOTE_SM));
  a_r4_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_stage && mode_q[1]) |=> done);
  a_r8_sm_ovf_like_signs: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf && mode_q == NOTE_SM) |-> (a_q[W-1] == (b_q[W-1] ^ sub_q)));

endmodule

// File: tb/snadd_top_tb.sv
module snadd_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0;
  logic [10:0] a = '0;
  logic [10:0] b = '0;
  logic        busy;
  logic        done;
  logic [10:0] result;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snadd_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sub(sub),
    .a(a), .b(b), .busy(busy), .done(done), .result(result), .ovf(ovf)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // signed value in units of 2^-10
  function automatic int wval(input logic [1:0] m, input logic [10:0] w);
    if (m == 2'b00) return w[10] ? -int'(w[9:0]) : int'(w[9:0]);
    if (m == 2'b01) return w[10] ? int'(w) - 2047 : int'(w);
    return w[10] ? int'(w) - 2048 : int'(w);
  endfunction

  task automatic do_op(input logic [1:0] m, input bit s, input logic [10:0] x,
                       input logic [10:0] y, input string req, input bit poke);
    int va, vb, e, lo, n;
    bit exp_ovf, got;
    int exp_lat;
    bit eff_bs;
    va = wval(m, x);
    vb = wval(m, y);
    e  = s ? va - vb : va + vb;
    lo = (m[1]) ? -1024 : -1023;
    exp_ovf = (e > 1023) || (e < lo);
    eff_bs  = y[10] ^ s;
    exp_lat = 1;
    if (m == 2'b00 && x[10] != eff_bs && x[9:0] <= y[9:0]) exp_lat = 2;

    @(negedge clk);
    mode = m; sub = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after capture", busy, 1);
    if (poke) begin
      start = 1'b1; a = ~x; b = ~y; sub = ~s; mode = ~m;
    end
    got = 1'b0; n = 0;
    for (int i = 1; i <= 4; i++) begin
      if (!got) begin
        @(negedge clk);
        start = 1'b0;
        if (done) begin got = 1'b1; n = i; end
      end
    end
    chk(got, req, "done seen", got, 1);
    chk(n == exp_lat, req, "latency", n, exp_lat);
    chk(busy == 1'b0, "R2", "busy low with done", busy, 0);
    chk(ovf == exp_ovf, req, "ovf", ovf, exp_ovf);
    if (m[1]) begin
      int wrap;
      wrap = (s ? (int'(x) + int'(~y & 11'h7FF) + 1) : (int'(x) + int'(y))) & 2047;
      chk(int'(result) == wrap, req, "twos bits", result, wrap);
    end else if (!exp_ovf) begin
      chk(wval(m, result) == e, req, "value", wval(m, result), e);
    end
    if (m == 2'b00 && exp_lat == 2)
      chk(result[10] == eff_bs, "R10", "sign", result[10], eff_bs);
    @(negedge clk);
    chk(done == 1'b0, "R2", "done single pulse", done, 0);
    if (poke) chk(busy == 1'b0 && done == 1'b0, "R3", "no extra operation", busy, 0);
  endtask

  task automatic test_reset();
    chk(busy == 0 && done == 0 && ovf == 0 && result == 0, "R1", "reset outputs",
        int'({busy, done, ovf, result}), 0);
  endtask

  task automatic test_twos();
    do_op(2'b10, 0, 11'd300, 11'd200, "R4", 0);
    do_op(2'b11, 0, 11'd300, 11'(2048-500), "R4", 0);
    do_op(2'b10, 1, 11'd100, 11'd250, "R4", 0);
    do_op(2'b10, 0, 11'd1023, 11'd1, "R5", 0);
    do_op(2'b10, 0, 11'h400, 11'h400, "R5", 0);
    do_op(2'b10, 1, 11'd0, 11'h400, "R5", 0);
    do_op(2'b10, 0, 11'h400, 11'd0, "R5", 0);
  endtask

  task automatic test_ones();
    do_op(2'b01, 0, 11'd5, 11'(2047-3), "R6", 0);
    do_op(2'b01, 0, 11'd5, 11'(2047-5), "R6", 0);
    do_op(2'b01, 0, 11'(2047-7), 11'(2047-9), "R6", 0);
    do_op(2'b01, 1, 11'd40, 11'd100, "R6", 0);
    do_op(2'b01, 0, 11'd1023, 11'd1, "R7", 0);
    do_op(2'b01, 1, 11'(2047-1000), 11'd100, "R7", 0);
  endtask

  task automatic test_sm();
    do_op(2'b00, 0, 11'd300, 11'd200, "R8", 0);
    do_op(2'b00, 0, 11'(1024+300), 11'(1024+200), "R8", 0);
    do_op(2'b00, 0, 11'd1023, 11'd1, "R8", 0);
    do_op(2'b00, 0, 11'd500, 11'(1024+200), "R9", 0);
    do_op(2'b00, 0, 11'(1024+500), 11'd499, "R9", 0);
    do_op(2'b00, 0, 11'd200, 11'(1024+500), "R10", 0);
    do_op(2'b00, 0, 11'(1024+3), 11'd3, "R10", 0);
    do_op(2'b00, 1, 11'd3, 11'd3, "R11", 0);
    do_op(2'b00, 1, 11'd600, 11'(1024+600), "R11", 0);
    do_op(2'b00, 1, 11'd100, 11'd700, "R11", 0);
  endtask

  task automatic test_busy_ignore();
    do_op(2'b00, 0, 11'd200, 11'(1024+500), "R3", 1);
    do_op(2'b10, 0, 11'd12, 11'd34, "R3", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_twos();
    test_ones();
    test_sm();
    test_busy_ignore();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule